// File: doc/BRIEF.md
# Serial-Addressed Octal Converter Code Register Bank

This block is the digital front end of an eight-channel, 8-bit converter. A host sends a load word over a three-wire serial link: a select line driven low to open a frame, a shift clock, and a data line. The block brings the three serial pins into the system clock domain through synchronizers. It shifts data in on rising shift-clock edges while the select is low. When the select returns high, it decodes the last 11 bits received into a 3-bit channel address followed by an 8-bit code, and writes that code into one of eight channel latches.

Two further controls act on the latch bank. An active-low preset drives every latch to the midscale code. A sleep input forces the outputs to zero. The latches are kept during sleep, and serial loads still reach them, so the outputs show the current latch values again as soon as sleep is released. The analog conversion that follows the latches is not part of this block.

Top module: `octal_dac_regs`

## Requirements
- R1: After reset every channel output reads 0x00.
- R2: A load word is sent most significant bit first. Of the final 11 bits, bits [10:8] are the channel address and bits [7:0] are the code. Address value k writes the code to output slot k (chan_code[k]), for k = 0 to 7.
- R3: A frame may carry more than 11 bits, for example two bytes with the address in the three lowest bits of the first byte. Only the last 11 bits shifted before the select rises are used, and all earlier bits are ignored.
- R4: A frame with fewer than 11 shift-clock rising edges while the select is low leaves every latch unchanged.
- R5: Shift-clock edges while the select is high do not shift data and change no output.
- R6: A valid frame is written when the select rises. The seven channels that are not addressed keep their values.
- R7: While preset_n is low, every latch is set to the midscale code 0x80.
- R8: If a frame completes in the same clock cycle that preset_n is low, the preset wins and the frame's write is discarded. It is not deferred.
- R9: While sleep is high every output reads 0x00. The latch values are kept and reappear unchanged when sleep goes low.
- R10: Frames that complete during sleep still update the latches, and the new values appear when sleep goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins and clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| preset_n | input | 1 | Active-low preset to midscale, synchronous to clk |
| sleep | input | 1 | Shutdown request; outputs read zero, latches retained |
| chan_code | output | NUM_CH x DATA_W (8 x 8) | Per-channel latched code, slot k = address k |

## Verification
The bench builds the block with its default parameters: a 3-bit address, an 8-bit code and two synchronizer stages. These defaults give all eight channels and exactly the 11-bit word boundary, so frames of 10, 11 and up to 16 bits are all exercised. The two-stage synchronizer fixes the latency from a select edge to a latch update. The bench waits well past that latency, so the check timing does not depend on the pipeline depth. A wider address or code would only scale the same frame-length boundary.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;
    localparam int DEF_ADDR_W      = 3;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_SYNC_STAGES = 2;

    // Midscale code: only the top bit set.
    function automatic logic [31:0] midscale(input int width);
        return 32'(1) << (width - 1);
    endfunction
endpackage

// File: rtl/octal_dac_sync.sv
module octal_dac_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/octal_dac_shifter.sv
module octal_dac_shifter #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int WORD_W = ADDR_W + DATA_W,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_clk,
    input  logic              s_data,
    input  logic              s_sel_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  bit_cnt
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              clk_prev;
        logic              sel_prev;
        logic              wr;
        logic [WORD_W-1:0] word;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr       = 1'b0;
        st_d.clk_prev = s_clk;
        st_d.sel_prev = s_sel_n;

        if (!s_sel_n && st_q.sel_prev) begin
            st_d.cnt = '0;
        end else if (!s_sel_n && s_clk && !st_q.clk_prev) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], s_data};
            if (st_q.cnt != CNT_W'(WORD_W)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (s_sel_n && !st_q.sel_prev) begin
            st_d.wr   = (st_q.cnt == CNT_W'(WORD_W));
            st_d.word = st_q.sr;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sel_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wr;
    assign wr_addr = st_q.word[WORD_W-1:DATA_W];
    assign wr_data = st_q.word[DATA_W-1:0];
    assign bit_cnt = st_q.cnt;
endmodule

// File: rtl/octal_dac_latches.sv
module octal_dac_latches #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int NUM_CH = 1 << ADDR_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           preset_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][DATA_W-1:0]  latch_q
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(octal_dac_pkg::midscale(DATA_W));

    logic [NUM_CH-1:0][DATA_W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!preset_n) begin
                latch_d[i] = MID;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                latch_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end
endmodule

// File: rtl/octal_dac_regs.sv
module octal_dac_regs #(
    parameter int ADDR_W      = octal_dac_pkg::DEF_ADDR_W,
    parameter int DATA_W      = octal_dac_pkg::DEF_DATA_W,
    parameter int SYNC_STAGES = octal_dac_pkg::DEF_SYNC_STAGES,
    localparam int NUM_CH = 1 << ADDR_W,
    localparam int WORD_W = ADDR_W + DATA_W,
    localparam int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_clk,
    input  logic                          ser_data,
    input  logic                          ser_sel_n,
    input  logic                          preset_n,
    input  logic                          sleep,
    output logic [NUM_CH-1:0][DATA_W-1:0] chan_code
);
    logic [2:0]                    pins_s;
    logic                          wr_en;
    logic [ADDR_W-1:0]             wr_addr;
    logic [DATA_W-1:0]             wr_data;
    logic [CNT_W-1:0]              frame_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0] latch_q;

    // Bit order: {select, data, clock}; select idles high.
    octal_dac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_sel_n, ser_data, ser_clk}),
        .sync_out (pins_s)
    );

    octal_dac_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_clk   (pins_s[0]),
        .s_data  (pins_s[1]),
        .s_sel_n (pins_s[2]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bit_cnt (frame_cnt)
    );

    octal_dac_latches #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_n (preset_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .latch_q  (latch_q)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_out
            assign chan_code[c] = sleep ? '0 : latch_q[c];
        end
    endgenerate
endmodule

// File: rtl/octal_dac_regs_chk.sv
module octal_dac_regs_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int WORD_W = 11,
    parameter int CNT_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          preset_n,
    input logic                          sleep,
    input logic                          wr_en,
    input logic [CNT_W-1:0]              frame_cnt,
    input logic [NUM_CH-1:0][DATA_W-1:0] latch_q
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(octal_dac_pkg::midscale(DATA_W));

    logic [NUM_CH-1:0][DATA_W-1:0] prev_q;
    logic [NUM_CH-1:0]             chg;
    logic                          all_mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= latch_q;
    end

    always_comb begin
        all_mid = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            chg[i] = (latch_q[i] != prev_q[i]);
            if (latch_q[i] != MID) all_mid = 1'b0;
        end
    end

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(preset_n) && !$past(wr_en)) |-> (chg == '0));

    a_r6_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(preset_n) |-> ($countones(chg) <= 1));

    a_r7_preset_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        !preset_n |=> all_mid);

    a_r8_preset_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_n && wr_en) |=> all_mid);

    a_r9_sleep_retains: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep) && $past(preset_n) && !$past(wr_en)) |-> $stable(latch_q));

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(WORD_W));
endmodule

bind octal_dac_regs octal_dac_regs_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset_n  (preset_n),
    .sleep     (sleep),
    .wr_en     (wr_en),
    .frame_cnt (frame_cnt),
    .latch_q   (latch_q)
);

// File: tb/octal_dac_regs_bench.sv
module octal_dac_regs_bench;
    localparam int NCH = 8;
    localparam int HP  = 4;  // clk cycles per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_sel_n = 1'b1;
    logic preset_n = 1'b1;
    logic sleep = 1'b0;
    logic [NCH-1:0][7:0] chan_code;

    logic [7:0] exp_q [NCH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    octal_dac_regs u_octal_dac_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_sel_n (ser_sel_n),
        .preset_n  (preset_n),
        .sleep     (sleep),
        .chan_code (chan_code)
    );

    function automatic logic [7:0] seen(input int ch);
        return sleep ? 8'h00 : exp_q[ch];
    endfunction

    task automatic check_all(input string req);
        for (int ch = 0; ch < NCH; ch++) begin
            checks++;
            if (chan_code[ch] !== seen(ch)) begin
                fails++;
                $display("FAIL %s ch%0d actual=%02h expected=%02h", req, ch, chan_code[ch], seen(ch));
            end
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of 'word' MSB first inside one select-low window.
    task automatic send(input int nbits, input logic [15:0] word);
        ser_sel_n = 1'b0;
        wait_clk(HP);
        for (int b = nbits - 1; b >= 0; b--) begin
            ser_data = word[b];
            wait_clk(HP);
            ser_clk = 1'b1;
            wait_clk(HP);
            ser_clk = 1'b0;
        end
        wait_clk(HP);
        ser_sel_n = 1'b1;
        wait_clk(12);
    endtask

    function automatic void model_load(input int nbits, input logic [15:0] word);
        if (nbits >= 11) exp_q[word[10:8]] = word[7:0];
    endfunction

    task automatic load(input int nbits, input logic [15:0] word);
        send(nbits, word);
        model_load(nbits, word);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int sel;
        int n;
        logic [15:0] w;
        void'($urandom(32'd1234));
        for (int i = 0; i < NCH; i++) exp_q[i] = 8'h00;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(5);
        check_all("R1");

        // R2: each address reaches its own slot, plain 11-bit words
        for (int a = 0; a < NCH; a++) begin
            load(11, {5'b0, 3'(a), 8'(8'h11 * (a + 1))});
            check_all("R2/R6");
        end

        // R3: two-byte form, junk in the upper five bits of the first byte
        load(16, {5'b10101, 3'd5, 8'hC3});
        check_all("R3");

        // R4: ten bits only, no update
        send(10, 16'h03FF);
        check_all("R4");

        // R5: shift-clock edges with the select high
        for (int k = 0; k < 14; k++) begin
            ser_data = k[0];
            wait_clk(HP);
            ser_clk = ~ser_clk;
        end
        ser_clk = 1'b0;
        wait_clk(12);
        check_all("R5");

        // R7: preset to midscale
        preset_n = 1'b0;
        wait_clk(3);
        preset_n = 1'b1;
        for (int i = 0; i < NCH; i++) exp_q[i] = 8'h80;
        wait_clk(2);
        check_all("R7");

        // R8: preset held low across a frame commit
        ser_sel_n = 1'b0;
        wait_clk(HP);
        w = {5'b0, 3'd2, 8'h5A};
        for (int b = 10; b >= 0; b--) begin
            ser_data = w[b];
            wait_clk(HP);
            ser_clk = 1'b1;
            wait_clk(HP);
            ser_clk = 1'b0;
        end
        wait_clk(HP);
        preset_n = 1'b0;
        ser_sel_n = 1'b1;
        wait_clk(12);
        preset_n = 1'b1;
        wait_clk(3);
        check_all("R8");

        // R9/R10: sleep hides outputs, keeps and updates latches
        load(11, {5'b0, 3'd6, 8'h3C});
        sleep = 1'b1;
        wait_clk(2);
        check_all("R9");
        load(11, {5'b0, 3'd1, 8'hE7});
        check_all("R10");
        sleep = 1'b0;
        wait_clk(2);
        check_all("R9/R10");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            sel = $urandom_range(0, 9);
            w = 16'($urandom);
            if (sel < 6) begin
                n = $urandom_range(11, 16);
                load(n, w);
                check_all("R3/R6");
            end else if (sel < 8) begin
                n = $urandom_range(1, 10);
                load(n, w);
                check_all("R4");
            end else if (sel == 8) begin
                sleep = 1'b1;
                load(11, w);
                check_all("R10");
                sleep = 1'b0;
                wait_clk(2);
                check_all("R10");
            end else begin
                preset_n = 1'b0;
                wait_clk(2);
                preset_n = 1'b1;
                for (int i = 0; i < NCH; i++) exp_q[i] = 8'h80;
                wait_clk(2);
                check_all("R7");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule